// File: doc/BRIEF.md
# Two-Bank Open-Row Memory Timing Controller

This block is a cycle-accurate timing front end for a 16-bit, byte-addressed, little-endian memory built from two banks. Each bank keeps one row open in its row buffer. A requester sends addresses through a valid/ready handshake. The controller splits each address into bank, column and row fields, using one of two selectable bit mappings. It then decides whether the target bank already holds that row. A miss pays the row-latch and row-open phases before the buffer read. A hit pays only the buffer read. Read data returns through a second valid/ready handshake.

Row-open phases in different banks may overlap. While a bank is opening a row, new requests to that same bank are held off. Every response leaves strictly in request order, at most one word per cycle. Responses can therefore back up behind a slow miss. A new address may be accepted in the same cycle that a word is returned. The storage behind the controller is a fixed behavioural array. Writes and refresh are not part of this block.

The linear mapping puts neighbouring words in alternate banks. The stride mapping moves the bank bit up to address bit 4, so that a stream with a 16-byte step alternates banks and shares rows.

Top module: `mem_row_ctrl`

## Requirements
- R1: After reset, req_ready_o is 1, rsp_valid_o is 0 and every bank's row is closed, so the first access to any bank is a miss.
- R2: A request that misses its bank's open row, accepted in cycle t (req_valid_i and req_ready_o both 1 at the clock edge that ends t), presents its data with rsp_valid_o = 1 in cycle t+8. This covers 2 cycles of row latch, 4 of row open, 1 buffer read and 1 to reach the bus, provided no older response is still waiting.
- R3: A request that hits the open row of its bank, accepted in cycle t, presents its data in cycle t+2, provided no older response is still waiting.
- R4: rsp_data_o[7:0] holds the byte at the even address {a[15:1],0} and rsp_data_o[15:8] holds the byte at {a[15:1],1}. Request address bit 0 has no effect. The stored byte at byte address b is b[7:0] XOR 8'hA5.
- R5: With map_sel_i = 0 (linear), address bit 1 selects the bank, bit 2 is the column and bits [15:3] form the row.
- R6: With map_sel_i = 1 (stride), bit 4 selects the bank, bit 5 is the column and the row is {a[15:6], a[3:1]}. A 16-byte stride therefore alternates banks and hits rows that are already open, while under map_sel_i = 0 the same stride stays in one bank and misses every time.
- R7: Misses to different banks overlap. Two back-to-back misses to bank 0 and then bank 1 return data in consecutive cycles.
- R8: After a miss to a bank is accepted in cycle t, requests to that bank see req_ready_o = 0 in cycles t+1 to t+6.
- R9: Responses leave in acceptance order, at most one per cycle. A hit accepted behind an older pending response returns in the cycle after that older response, not earlier.
- R10: While rsp_valid_o = 1 and rsp_ready_i = 0, rsp_valid_o stays 1 and rsp_data_o stays unchanged.
- R11: map_sel_i may change only when no response is pending and no bank is opening a row. A change of map_sel_i closes every open row.
- R12: At most 4 accepted requests are outstanding. With 4 outstanding, req_ready_o is 0 until a response is taken.
- R13: A request can be accepted in the same cycle that a response is handed over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| map_sel_i | input | 1 | Address mapping: 0 linear, 1 stride |
| req_valid_i | input | 1 | Request address valid |
| req_addr_i | input | 16 | Request byte address |
| req_ready_o | output | 1 | Request can be accepted this cycle |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_ready_i | input | 1 | Requester takes the read data |
| rsp_data_o | output | 16 | Read word, lower address byte in bits [7:0] |

## Verification
A stale open-row register or a lost valid bit makes an access that should hit take eight cycles, or one that should miss take two. That shows up as a response one or six cycles off its expected slot on the very access that uses the bad entry. A stuck bank-busy counter shows at once in req_ready_o: either the stall window before the next same-bank request is longer or shorter than expected, or a stream that should overlap across banks serialises instead. A wrong countdown in the response queue moves a response to the wrong cycle or returns data out of order. Each response is compared against the word for its own address, so that error also shows on the first response it touches.

// File: rtl/mem_row_pkg.sv
package mem_row_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int NBANKS = 2;
  localparam int BANK_W = 1;
  localparam int ROW_W  = 13;

  typedef enum logic {MAP_LINEAR = 1'b0, MAP_STRIDE = 1'b1} map_mode_e;
  typedef logic [ROW_W-1:0]  row_t;
  typedef logic [BANK_W-1:0] bank_t;
endpackage

// File: rtl/mem_row_addr_map.sv
module mem_row_addr_map
  import mem_row_pkg::*;
(
  input  logic [ADDR_W-2:0] waddr_i,   // byte address without bit 0
  input  map_mode_e         mode_i,
  output bank_t             bank_o,
  output row_t              row_o
);
  always_comb begin
    unique case (mode_i)
      MAP_LINEAR: begin
        bank_o = waddr_i[0];
        row_o  = waddr_i[ADDR_W-2:2];
      end
      default: begin
        bank_o = waddr_i[3];
        row_o  = {waddr_i[ADDR_W-2:5], waddr_i[2:0]};
      end
    endcase
  end
endmodule

// File: rtl/mem_row_bank_track.sv
module mem_row_bank_track
  import mem_row_pkg::*;
#(
  parameter int BUSY_CYC = 6
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  bank_t bank_i,
  input  row_t  row_i,
  input  logic  accept_i,
  input  logic  remap_i,
  output logic  hit_o,
  output logic  busy_o,
  output logic  any_busy_o
);
  localparam int BW = $clog2(BUSY_CYC + 1);

  row_t              open_row_q [NBANKS];
  logic [NBANKS-1:0] open_vld_q;
  logic [BW-1:0]     busy_q     [NBANKS];
  logic [NBANKS-1:0] busy_vec;

  assign hit_o      = open_vld_q[bank_i] && (open_row_q[bank_i] == row_i) && !remap_i;
  assign busy_o     = busy_vec[bank_i];
  assign any_busy_o = |busy_vec;

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    logic sel;
    assign sel         = accept_i && (bank_i == BANK_W'(b));
    assign busy_vec[b] = (busy_q[b] != '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_row_q[b] <= '0;
        open_vld_q[b] <= 1'b0;
        busy_q[b]     <= '0;
      end else begin
        if (busy_vec[b]) busy_q[b] <= busy_q[b] - 1'b1;
        if (remap_i) open_vld_q[b] <= 1'b0;
        // a miss starts latch + open; row is tracked from acceptance
        if (sel && !hit_o) begin
          open_row_q[b] <= row_i;
          open_vld_q[b] <= 1'b1;
          busy_q[b]     <= BW'(BUSY_CYC);
        end
      end
    end

    assert_bank_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel |-> (busy_q[b] == '0));
  end
endmodule

// File: rtl/mem_row_resp_q.sv
module mem_row_resp_q #(
  parameter int PTR_W = 2,
  parameter int AW    = 7,
  parameter int CW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] push_idx_i,
  input  logic [CW-1:0] push_lat_i,   // cycles to data, minus one
  input  logic          pop_ready_i,
  output logic          full_o,
  output logic          empty_o,
  output logic          head_valid_o,
  output logic [AW-1:0] head_idx_o
);
  localparam int DEPTH = 1 << PTR_W;
  localparam int NW    = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] vld_q;
  logic [AW-1:0]    idx_q [DEPTH];
  logic [CW-1:0]    cnt_q [DEPTH];
  logic [PTR_W-1:0] head_q, tail_q, last;
  logic [NW-1:0]    num_q;
  logic [CW-1:0]    tail_cnt, new_cnt;
  logic             pop;

  assign full_o       = (num_q == NW'(DEPTH));
  assign empty_o      = (num_q == '0);
  assign head_valid_o = vld_q[head_q] && (cnt_q[head_q] == '0);
  assign head_idx_o   = idx_q[head_q];
  assign pop          = head_valid_o && pop_ready_i;

  // in-order return: never earlier than one cycle after the youngest entry
  assign last     = tail_q - 1'b1;
  assign tail_cnt = empty_o ? '0 : cnt_q[last];
  assign new_cnt  = (tail_cnt > push_lat_i) ? tail_cnt : push_lat_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
      num_q  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        idx_q[i] <= '0;
        cnt_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (vld_q[i] && cnt_q[i] != '0) cnt_q[i] <= cnt_q[i] - 1'b1;
      if (pop) begin
        vld_q[head_q] <= 1'b0;
        head_q        <= head_q + 1'b1;
      end
      if (push_i) begin
        vld_q[tail_q] <= 1'b1;
        idx_q[tail_q] <= push_idx_i;
        cnt_q[tail_q] <= new_cnt;
        tail_q        <= tail_q + 1'b1;
      end
      num_q <= num_q + NW'(push_i) - NW'(pop);
    end
  end

  assert_no_overflow_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !push_i);

  assert_hold_data_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (head_valid_o && !pop_ready_i) |=> (head_valid_o && $stable(head_idx_o)));
endmodule

// File: rtl/mem_row_array.sv
module mem_row_array
  import mem_row_pkg::*;
#(
  parameter int WORDS = 128
) (
  input  logic [$clog2(WORDS)-1:0] rd_idx_i,
  output logic [DATA_W-1:0]        rd_data_o
);
  logic [DATA_W-1:0] words [WORDS];

  // fixed content: byte at address b holds b[7:0] ^ 8'hA5
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    assign words[g] = {8'(2 * g + 1) ^ 8'hA5, 8'(2 * g) ^ 8'hA5};
  end

  assign rd_data_o = words[rd_idx_i];
endmodule

// File: rtl/mem_row_ctrl.sv
module mem_row_ctrl
  import mem_row_pkg::*;
#(
  parameter int T_LATCH   = 2,
  parameter int T_OPEN    = 4,
  parameter int T_READ    = 1,
  parameter int Q_PTR_W   = 2,
  parameter int MEM_WORDS = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              map_sel_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [DATA_W-1:0] rsp_data_o
);
  localparam int MISS_LAT = T_LATCH + T_OPEN + T_READ + 1;
  localparam int HIT_LAT  = T_READ + 1;
  localparam int BUSY_CYC = T_LATCH + T_OPEN;
  localparam int CW       = $clog2(MISS_LAT + 1);
  localparam int IDX_W    = $clog2(MEM_WORDS);

  map_mode_e  mode_q, mode_in;
  bank_t      bank;
  row_t       row;
  logic       remap, hit, busy, any_busy, full, empty, accept, idle;
  logic [IDX_W-1:0] head_idx;
  logic       byte_unused;

  assign byte_unused = req_addr_i[0];
  assign mode_in     = map_mode_e'(map_sel_i);
  assign remap       = (mode_in != mode_q);
  assign idle        = empty && !any_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MAP_LINEAR;
    else         mode_q <= mode_in;
  end

  mem_row_addr_map i_map (
    .waddr_i (req_addr_i[ADDR_W-1:1]),
    .mode_i  (mode_in),
    .bank_o  (bank),
    .row_o   (row)
  );

  mem_row_bank_track #(.BUSY_CYC(BUSY_CYC)) i_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bank_i     (bank),
    .row_i      (row),
    .accept_i   (accept),
    .remap_i    (remap),
    .hit_o      (hit),
    .busy_o     (busy),
    .any_busy_o (any_busy)
  );

  assign req_ready_o = !full && !busy;
  assign accept      = req_valid_i && req_ready_o;

  mem_row_resp_q #(.PTR_W(Q_PTR_W), .AW(IDX_W), .CW(CW)) i_q (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (accept),
    .push_idx_i   (req_addr_i[IDX_W:1]),
    .push_lat_i   (hit ? CW'(HIT_LAT - 1) : CW'(MISS_LAT - 1)),
    .pop_ready_i  (rsp_ready_i),
    .full_o       (full),
    .empty_o      (empty),
    .head_valid_o (rsp_valid_o),
    .head_idx_o   (head_idx)
  );

  mem_row_array #(.WORDS(MEM_WORDS)) i_arr (
    .rd_idx_i  (head_idx),
    .rd_data_o (rsp_data_o)
  );

  assert_remap_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    remap |-> idle);

  assert_remap_miss_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    remap |-> !hit);
endmodule

// File: tb/test_mem_row_ctrl.sv
module test_mem_row_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, map_sel = 1'b0, req_valid = 1'b0, rsp_ready = 1'b1;
  logic [15:0] req_addr = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_data;

  mem_row_ctrl i_mem_row_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .map_sel_i(map_sel),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_ready_o(req_ready),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_data_o(rsp_data)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  int          r_cyc [64];
  logic [15:0] r_dat [64];
  int          r_n = 0;

  always @(negedge clk) begin
    #2;
    if (rst_n && rsp_valid && rsp_ready) begin
      r_cyc[r_n % 64] = cyc;
      r_dat[r_n % 64] = rsp_data;
      r_n++;
    end
  end

  logic [15:0] s_addr [8];
  int          s_acc  [8];
  int          s_st   [8];

  function automatic logic [15:0] exp_word(input logic [15:0] a);
    logic [7:0] lo, hi;
    lo = {a[7:1], 1'b0} ^ 8'hA5;
    hi = {a[7:1], 1'b1} ^ 8'hA5;
    return {hi, lo};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [15:0] a, output int acc, output int stalls);
    stalls = 0;
    req_valid = 1'b1;
    req_addr  = a;
    #1;
    while (!req_ready && stalls < 400) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    acc = cyc;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain(input int n);
    int guard = 0;
    while (r_n < n && guard < 400) begin
      @(negedge clk);
      #3;
      guard++;
    end
    repeat (10) @(negedge clk);
  endtask

  task automatic run_stream(input int n);
    r_n = 0;
    for (int i = 0; i < n; i++) issue(s_addr[i], s_acc[i], s_st[i]);
    drain(n);
    check(r_n == n, "R9 response count", r_n, n);
  endtask

  task automatic access(input logic [15:0] a, input int exp_lat, input string req);
    int acc, st;
    r_n = 0;
    issue(a, acc, st);
    drain(1);
    check(r_n == 1 && r_cyc[0] - acc == exp_lat, req, r_cyc[0] - acc, exp_lat);
    check(r_dat[0] == exp_word(a), "R4 data word", r_dat[0], exp_word(a));
  endtask

  task automatic t_reset;
    #1;
    check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    check(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);
  endtask

  task automatic t_single;
    access(16'h1000, 8, "R1 R2 first access misses");
    access(16'h1001, 2, "R3 R4 hit, bit0 ignored");
    check(r_dat[0] == exp_word(16'h1000), "R4 bit0 no effect", r_dat[0], exp_word(16'h1000));
    access(16'h1004, 2, "R5 column bit2 keeps row");
    access(16'h1006, 8, "R5 bank bit1 other bank closed");
    access(16'h1008, 8, "R5 row bit3 changes row");
  endtask

  task automatic t_linear_stream;
    int rel [5] = '{8, 9, 10, 11, 17};
    s_addr[0] = 16'h5000; s_addr[1] = 16'h5002; s_addr[2] = 16'h5004;
    s_addr[3] = 16'h5006; s_addr[4] = 16'h5008;
    run_stream(5);
    check(s_acc[1] - s_acc[0] == 1, "R7 other bank accepted next cycle", s_acc[1] - s_acc[0], 1);
    check(s_st[2] == 5, "R8 same-bank stall cycles", s_st[2], 5);
    check(s_acc[2] - s_acc[0] == 7, "R8 same-bank accept after open", s_acc[2] - s_acc[0], 7);
    check(s_acc[3] - s_acc[0] == 8 && r_cyc[0] - s_acc[0] == 8,
          "R13 accept with response", s_acc[3] - s_acc[0], 8);
    for (int i = 0; i < 5; i++) begin
      check(r_cyc[i] - s_acc[0] == rel[i], "R7 R9 return cycle", r_cyc[i] - s_acc[0], rel[i]);
      check(r_dat[i] == exp_word(s_addr[i]), "R9 order and data", r_dat[i], exp_word(s_addr[i]));
    end
  endtask

  task automatic t_stride;
    int rel_s [4] = '{8, 9, 10, 11};
    int rel_l [4] = '{8, 15, 22, 29};
    map_sel = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 4; i++) s_addr[i] = 16'h2000 + 16'(i * 16);
    run_stream(4);
    for (int i = 0; i < 4; i++) begin
      check(r_cyc[i] - s_acc[0] == rel_s[i], "R6 stride map alternates banks", r_cyc[i] - s_acc[0], rel_s[i]);
      check(r_dat[i] == exp_word(s_addr[i]), "R6 data", r_dat[i], exp_word(s_addr[i]));
    end
    map_sel = 1'b0;
    @(negedge clk);
    access(16'h2000, 8, "R11 remap closes rows");
    for (int i = 0; i < 4; i++) s_addr[i] = 16'h3000 + 16'(i * 16);
    run_stream(4);
    for (int i = 0; i < 4; i++)
      check(r_cyc[i] - s_acc[0] == rel_l[i], "R6 linear map serialises stride", r_cyc[i] - s_acc[0], rel_l[i]);
  endtask

  task automatic t_backpressure;
    int acc, st;
    logic [15:0] first;
    r_n = 0;
    rsp_ready = 1'b0;
    issue(16'h6000, acc, st);
    while (cyc < acc + 8) @(negedge clk);
    #1;
    check(rsp_valid == 1'b1, "R2 valid under backpressure", rsp_valid, 1);
    first = rsp_data;
    check(first == exp_word(16'h6000), "R4 data", first, exp_word(16'h6000));
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      #1;
      check(rsp_valid == 1'b1 && rsp_data == first, "R10 hold while stalled", rsp_data, first);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    #3;
    check(r_n == 1, "R10 taken once", r_n, 1);
    check(rsp_valid == 1'b0, "R10 cleared after take", rsp_valid, 0);
    repeat (10) @(negedge clk);
  endtask

  task automatic t_full;
    int acc, st;
    logic [15:0] a [5] = '{16'h7000, 16'h7002, 16'h7004, 16'h7006, 16'h7004};
    r_n = 0;
    rsp_ready = 1'b0;
    for (int i = 0; i < 4; i++) issue(a[i], acc, st);
    repeat (10) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a[4];
    for (int i = 0; i < 5; i++) begin
      #1;
      check(req_ready == 1'b0, "R12 ready low with 4 outstanding", req_ready, 0);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    issue(a[4], acc, st);
    drain(5);
    check(r_n == 5, "R12 all responses", r_n, 5);
    for (int i = 0; i < 5; i++)
      check(r_dat[i] == exp_word(a[i]), "R12 order after full", r_dat[i], exp_word(a[i]));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_linear_stream();
    t_stride();
    t_backpressure();
    t_full();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R9: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule